// File: doc/BRIEF.md
# Serial Frame Transmitter with Even Parity

This block turns one parallel byte into an asynchronous serial frame on a single output line. A one-cycle start pulse captures the byte into an internal register and arms the sender. From the next baud tick onward, the line carries a low start bit, then the data bits from the least significant bit up, then an even parity bit, then a high stop bit. Each bit lasts exactly one baud tick period. When the stop bit period ends, a completion flag rises and stays high until the next start pulse.

The baud tick is an external single-cycle enable. The tick rate sets the bit rate, so slow rates such as 110 b/s and fast rates such as 9600 b/s come from the same logic. Internally the block has two parts. A datapath holds the frame shift register, the parity bit and the bit counter. A small control state machine steps that datapath, one tick at a time, and reads back the counter's terminal flag.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the serial line `txd` is 1 and `done` is 0.
- R2: After a start pulse is accepted, `txd` stays 1 until the first baud tick that follows. At that tick the line drops to 0, which is the start bit.
- R3: Eight data bits follow the start bit in order, bit 0 first and bit 7 last.
- R4: The bit after the data is the parity bit. Its value gives the data byte plus that bit an even number of ones.
- R5: The bit after the parity bit is a stop bit of value 1. The line then stays 1 while idle.
- R6: `txd` changes only in the cycle right after a cycle in which `tick` is 1. Each frame bit is therefore held for one full tick period.
- R7: `done` rises at the tick that ends the stop bit. It stays 1 until the next start pulse, and it returns to 0 in the cycle after that pulse.
- R8: The byte on `din` is captured in the cycle of the start pulse. Changes on `din` later in the frame do not alter the transmitted bits.
- R9: A start pulse that arrives while a frame is armed or being sent has no effect. The frame and the timing of `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle baud enable, once per bit period |
| start | input | 1 | One-cycle request to send the byte on `din` |
| din | input | DATA_W | Parallel data byte |
| txd | output | 1 | Serial line, idle high |
| done | output | 1 | Frame-complete flag |

## Verification
A fault in the bit counter or the shift register appears at once on `txd`. A frame gains or loses a bit, or shows a wrong level at a given tick. The bench compares every bit position at the tick edge and again just before the next tick. A stuck or mis-sequenced state machine appears within one bit period: a start bit arrives too early, the line moves between ticks, or `done` rises at the wrong tick or falls without a start pulse. A missing busy guard surfaces in the frame that is in flight, as altered bits after a mid-frame pulse.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              done
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_SEND} state_t;

  state_t               state;
  logic [FRAME_W-1:0]   frame_q;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 txd_q;
  logic                 done_q;

  // control outputs of the FSM
  logic load, shift, finish;
  // status flag from the datapath
  logic last_bit;

  assign last_bit = (bit_cnt == CNT_W'(FRAME_W));

  always_comb begin
    load   = 1'b0;
    shift  = 1'b0;
    finish = 1'b0;
    case (state)
      S_IDLE: load = start;
      S_ARM:  shift = tick;
      S_SEND: begin
        finish = tick & last_bit;
        shift  = tick & ~last_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE:  if (load) state <= S_ARM;
        S_ARM:   if (shift) state <= S_SEND;
        S_SEND:  if (finish) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // datapath: frame register, parity, bit counter, line register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      bit_cnt <= '0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      if (load) begin
        frame_q <= {1'b1, ^din, din, 1'b0};
        bit_cnt <= '0;
        done_q  <= 1'b0;
      end else if (shift) begin
        txd_q   <= frame_q[0];
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (finish) begin
        txd_q   <= 1'b1;
        done_q  <= 1'b1;
      end
    end
  end

  assign txd  = txd_q;
  assign done = done_q;

  p_line_moves_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (state == S_ARM && !done && txd));

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARM && start && !tick) |=> (state == S_ARM));

  p_idle_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> txd);

  p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
  localparam int DATA_W = 8;
  localparam int TICKP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic txd, done;
  int checks = 0;
  int errors = 0;
  int tc = 0;

  uart_frame_tx #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .din(din), .txd(txd), .done(done));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tc   <= 0;
      tick <= 1'b0;
    end else begin
      tc   <= (tc == TICKP-1) ? 0 : tc + 1;
      tick <= (tc == TICKP-1);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
  endtask

  // mode 0: plain, 1: start pulse mid-frame, 2: din change mid-frame
  task automatic send_frame(input logic [DATA_W-1:0] data, input int mode, input int at);
    logic [DATA_W+2:0] exp;
    string tag;
    exp = {1'b1, ^data, data, 1'b0};
    @(negedge clk);
    din = data;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    check("R7 done clears on start", done, 1'b0);
    check("R2 line high before first tick", txd, 1'b1);
    for (int k = 0; k < DATA_W + 3; k++) begin
      wait_tick();
      #1;
      tag = (k == 0) ? "R2 start bit" : (k <= DATA_W) ? "R3 data bit" :
            (k == DATA_W + 1) ? "R4 parity bit" : "R5 stop bit";
      if (mode == 1) tag = {tag, " R9"};
      if (mode == 2) tag = {tag, " R8"};
      check(tag, txd, exp[k]);
      check("R7 done low in frame", done, 1'b0);
      if (k == at && mode != 0) begin
        din = ~data;
        if (mode == 1) start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (TICKP-3) @(posedge clk);
      end else begin
        repeat (TICKP-2) @(posedge clk);
      end
      #1 check("R6 bit held until next tick", txd, exp[k]);
    end
    wait_tick();
    #1;
    check("R7 done after stop bit", done, 1'b1);
    check("R5 idle line high", txd, 1'b1);
  endtask

  task automatic test_reset();
    #1;
    check("R1 txd after reset", txd, 1'b1);
    check("R1 done after reset", done, 1'b0);
  endtask

  task automatic test_done_hold();
    repeat (3 * TICKP) @(posedge clk);
    #1;
    check("R7 done holds while idle", done, 1'b1);
    check("R5 line stays high", txd, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    test_reset();
    send_frame(8'h00, 0, -1);
    send_frame(8'hFF, 0, -1);
    send_frame(8'hA5, 0, -1);
    send_frame(8'h01, 0, -1);
    send_frame(8'h80, 0, -1);
    test_done_hold();
    send_frame(8'h3C, 1, 0);
    send_frame(8'h5B, 1, 5);
    send_frame(8'hC6, 1, 10);
    send_frame(8'h96, 2, 2);
    send_frame(8'h71, 0, -1);
    test_done_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule